// File: doc/BRIEF.md
# Programmable Sum-of-Products Plane

This block is the logic core of a small field-programmable logic device. Eight dedicated inputs and eight feedback or pin signals are each presented in true and complement form, which gives 32 array lines. Sixty-four product terms each AND together whichever of those lines their connection word selects. The terms are arranged in eight groups of eight, one group per output. Each group ORs its terms into one sum output.

The last term of every group is the special term. It is always visible on its own output. A per-group select decides whether that term also joins the group's OR, or stays out of it so that the surrounding logic can use it as an output-enable condition.

The connection map is held in flops. It is written and read one term at a time through an address/data port with a write strobe. A clear input opens every connection at once, which is the erased state. Evaluation is purely combinational. The clock only serves the map port.

Top module: `sop_plane`

## Requirements
- R1: Array line 2k carries the true form and line 2k+1 the complement form of signal k. Signals 0..7 are `ded_i[0..7]` and signals 8..15 are `fb_i[0..7]`.
- R2: Product term t ANDs exactly the array lines l for which bit l of map word t is 1. A 1 bit means connected.
- R3: A product term whose map word is all zero evaluates to 1.
- R4: A product term connected to both line 2k and line 2k+1 evaluates to 0, whatever the inputs.
- R5: `sum_o[g]` is the OR of terms 8g..8g+6, plus term 8g+7 when `xt_oe_sel[g]` is 0.
- R6: When `xt_oe_sel[g]` is 1, term 8g+7 has no effect on `sum_o[g]`.
- R7: `xterm_o[g]` always equals the value of term 8g+7.
- R8: When `map_we` is high at a rising clock edge, `map_wdata` is stored as map word `map_addr`. `map_rdata` shows word `map_addr` combinationally.
- R9: When `map_clr` is high at a rising clock edge, every map bit becomes 0. A write in the same cycle is discarded.
- R10: When `rst_n` is low at a rising clock edge, every map bit becomes 0.
- R11: `sum_o` and `xterm_o` follow changes on `ded_i`, `fb_i` and `xt_oe_sel` with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the map port |
| rst_n | input | 1 | Synchronous active-low reset; opens all connections |
| map_clr | input | 1 | Synchronous erase of the whole map |
| map_we | input | 1 | Write strobe for one map word |
| map_addr | input | 6 | Product-term index for write and read |
| map_wdata | input | 32 | Connection word to write |
| map_rdata | output | 32 | Connection word at `map_addr` |
| ded_i | input | 8 | Dedicated input signals |
| fb_i | input | 8 | Feedback or pin signals |
| xt_oe_sel | input | 8 | Per group: 1 keeps the special term out of the OR |
| sum_o | output | 8 | Sum-of-products outputs |
| xterm_o | output | 8 | Special product term of each group |

## Verification
Sparse random maps are the main stimulus, built by ANDing several random words so that product terms are true often enough. They are evaluated against random input vectors and random group selects. This separates a wrong line mapping, a swapped polarity or a wrong term-to-group assignment, each of which would flip outputs a dense map would keep at 0.

Directed patterns cover the following cases:
- An erased array, where every output is 1.
- Contradictory terms that pull a sum to 0.
- A group whose only true term is its special term, toggled between its two uses.
- A clear that collides with a write.
- An input change with the clock held still.

// File: rtl/sop_plane_pkg.sv
// Package: shared encodings for the sum-of-products plane.
// Assumes: the special term is the last term of each group.
package sop_plane_pkg;

    // Use of the special term of one group
    typedef enum logic {
        XT_IN_SUM = 1'b0,
        XT_AS_OE  = 1'b1
    } xterm_use_e;

    // Array line carrying the true form of signal k
    function automatic int true_line(input int k);
        return 2 * k;
    endfunction

    // Array line carrying the complement form of signal k
    function automatic int comp_line(input int k);
        return 2 * k + 1;
    endfunction

endpackage

// File: rtl/sop_line_builder.sv
// Module: forms the array lines from the dedicated and feedback signals.
// Assumes: signal k drives line 2k (true) and line 2k+1 (complement),
// with the dedicated signals first and then the feedback signals.
module sop_line_builder #(
    parameter int N_DED = 8,
    parameter int N_FB  = 8,
    localparam int N_SIG   = N_DED + N_FB,
    localparam int N_LINES = 2 * N_SIG
) (
    input  logic [N_DED-1:0]   ded_i,
    input  logic [N_FB-1:0]    fb_i,
    output logic [N_LINES-1:0] lines_o
);
    import sop_plane_pkg::*;

    logic [N_SIG-1:0] sig;

    // Concatenate the signals in line order
    always_comb begin
        sig = {fb_i, ded_i};
    end

    for (genvar k = 0; k < N_SIG; k++) begin : g_sig
        assign lines_o[true_line(k)] = sig[k];
        assign lines_o[comp_line(k)] = ~sig[k];
    end

endmodule

// File: rtl/sop_map_store.sv
// Module: flop storage for the connection map, one word per product term.
// Assumes: synchronous active-low reset; clear has priority over write;
// addresses at or beyond N_TERMS write nothing and read back zero.
module sop_map_store #(
    parameter int N_TERMS = 64,
    parameter int N_LINES = 32,
    localparam int AW = $clog2(N_TERMS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clr,
    input  logic                             we,
    input  logic [AW-1:0]                    addr,
    input  logic [N_LINES-1:0]               wdata,
    output logic [N_LINES-1:0]               rdata,
    output logic [N_TERMS-1:0][N_LINES-1:0]  map_o
);

    logic [N_TERMS-1:0][N_LINES-1:0] map_q;

    // Update the map: reset or clear opens all connections, else write one word
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            map_q <= '0;
        end else if (we && (int'(addr) < N_TERMS)) begin
            map_q[addr] <= wdata;
        end
    end

    // Combinational read-back of the addressed word
    always_comb begin
        rdata = '0;
        if (int'(addr) < N_TERMS) begin
            rdata = map_q[addr];
        end
    end

    assign map_o = map_q;

endmodule

// File: rtl/sop_term_eval.sv
// Module: evaluates every product term as an AND over its connected lines.
// Assumes: a 1 map bit means connected; an open bit does not constrain the term.
module sop_term_eval #(
    parameter int N_TERMS = 64,
    parameter int N_LINES = 32
) (
    input  logic [N_LINES-1:0]              lines_i,
    input  logic [N_TERMS-1:0][N_LINES-1:0] map_i,
    output logic [N_TERMS-1:0]              term_o
);

    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        // An open bit forces its input of the AND to 1
        always_comb begin
            term_o[t] = &(lines_i | ~map_i[t]);
        end
    end

endmodule

// File: rtl/sop_or_collect.sv
// Module: ORs each group's terms into one sum, and routes the special term.
// Assumes: group g owns terms GRP*g .. GRP*g+GRP-1, and the last one is special.
module sop_or_collect #(
    parameter int N_OUT = 8,
    parameter int GRP   = 8,
    localparam int N_TERMS = N_OUT * GRP
) (
    input  logic [N_TERMS-1:0] term_i,
    input  logic [N_OUT-1:0]   xt_oe_sel,
    output logic [N_OUT-1:0]   sum_o,
    output logic [N_OUT-1:0]   xterm_o
);
    import sop_plane_pkg::*;

    for (genvar g = 0; g < N_OUT; g++) begin : g_grp
        logic [GRP-2:0] base_terms;
        logic           special;
        xterm_use_e     use_sel;

        assign base_terms = term_i[GRP*g +: GRP-1];
        assign special    = term_i[GRP*g + GRP-1];
        assign use_sel    = xterm_use_e'(xt_oe_sel[g]);

        // Sum the group; the special term joins only when it is not an enable
        always_comb begin
            sum_o[g] = (|base_terms) || ((use_sel == XT_IN_SUM) && special);
        end

        assign xterm_o[g] = special;
    end

endmodule

// File: rtl/sop_plane.sv
// Module: top of the programmable sum-of-products plane.
// Assumes: the map port is clocked; the evaluation path has no clock.
module sop_plane #(
    parameter int N_DED = 8,
    parameter int N_FB  = 8,
    parameter int N_OUT = 8,
    parameter int GRP   = 8,
    localparam int N_LINES = 2 * (N_DED + N_FB),
    localparam int N_TERMS = N_OUT * GRP,
    localparam int AW      = $clog2(N_TERMS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               map_clr,
    input  logic               map_we,
    input  logic [AW-1:0]      map_addr,
    input  logic [N_LINES-1:0] map_wdata,
    output logic [N_LINES-1:0] map_rdata,
    input  logic [N_DED-1:0]   ded_i,
    input  logic [N_FB-1:0]    fb_i,
    input  logic [N_OUT-1:0]   xt_oe_sel,
    output logic [N_OUT-1:0]   sum_o,
    output logic [N_OUT-1:0]   xterm_o
);

    logic [N_LINES-1:0]              lines;
    logic [N_TERMS-1:0][N_LINES-1:0] map;
    logic [N_TERMS-1:0]              terms;

    sop_line_builder #(.N_DED(N_DED), .N_FB(N_FB)) u_lines (
        .ded_i   (ded_i),
        .fb_i    (fb_i),
        .lines_o (lines)
    );

    sop_map_store #(.N_TERMS(N_TERMS), .N_LINES(N_LINES)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (map_clr),
        .we    (map_we),
        .addr  (map_addr),
        .wdata (map_wdata),
        .rdata (map_rdata),
        .map_o (map)
    );

    sop_term_eval #(.N_TERMS(N_TERMS), .N_LINES(N_LINES)) u_eval (
        .lines_i (lines),
        .map_i   (map),
        .term_o  (terms)
    );

    sop_or_collect #(.N_OUT(N_OUT), .GRP(GRP)) u_or (
        .term_i    (terms),
        .xt_oe_sel (xt_oe_sel),
        .sum_o     (sum_o),
        .xterm_o   (xterm_o)
    );

endmodule

// File: rtl/sop_plane_chk.sv
// Module: assertion checker bound to the sum-of-products plane.
// Assumes: it observes the top-level ports only.
module sop_plane_chk #(
    parameter int N_LINES = 32,
    parameter int N_OUT   = 8,
    parameter int AW      = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               map_clr,
    input logic               map_we,
    input logic [AW-1:0]      map_addr,
    input logic [N_LINES-1:0] map_wdata,
    input logic [N_LINES-1:0] map_rdata,
    input logic [N_OUT-1:0]   xt_oe_sel,
    input logic [N_OUT-1:0]   sum_o,
    input logic [N_OUT-1:0]   xterm_o
);

    // R8: a written word reads back while the address is held
    assert_write_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (map_we && !map_clr) |=>
            ((map_addr != $past(map_addr)) || (map_rdata == $past(map_wdata))));

    // R9 / R3: after a clear the map is empty and every special term is true
    assert_clear_opens_R9: assert property (@(posedge clk) disable iff (!rst_n)
        map_clr |=> ((map_rdata == '0) && (&xterm_o)));

    // R5: a true special term that feeds the OR forces its sum high
    assert_special_in_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((~xt_oe_sel & xterm_o & ~sum_o) == '0));

    // R10: leaving reset, the map reads empty
    assert_reset_empty_R10: assert property (@(posedge clk)
        ($rose(rst_n) && !map_we) |-> (map_rdata == '0));

endmodule

bind sop_plane sop_plane_chk #(
    .N_LINES (N_LINES),
    .N_OUT   (N_OUT),
    .AW      (AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .map_clr   (map_clr),
    .map_we    (map_we),
    .map_addr  (map_addr),
    .map_wdata (map_wdata),
    .map_rdata (map_rdata),
    .xt_oe_sel (xt_oe_sel),
    .sum_o     (sum_o),
    .xterm_o   (xterm_o)
);

// File: tb/sop_plane_bench.sv
module sop_plane_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_clr = 1'b0;
    logic        map_we = 1'b0;
    logic [5:0]  map_addr = '0;
    logic [31:0] map_wdata = '0;
    logic [31:0] map_rdata;
    logic [7:0]  ded_i = '0;
    logic [7:0]  fb_i = '0;
    logic [7:0]  xt_oe_sel = '0;
    logic [7:0]  sum_o;
    logic [7:0]  xterm_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] mdl [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    sop_plane u_sop_plane (
        .clk(clk), .rst_n(rst_n), .map_clr(map_clr), .map_we(map_we),
        .map_addr(map_addr), .map_wdata(map_wdata), .map_rdata(map_rdata),
        .ded_i(ded_i), .fb_i(fb_i), .xt_oe_sel(xt_oe_sel),
        .sum_o(sum_o), .xterm_o(xterm_o)
    );

    // Value of array line l from the signals (R1)
    function automatic logic line_val(int l, logic [7:0] d, logic [7:0] f);
        int k = l / 2;
        logic s = (k < 8) ? d[k] : f[k-8];
        return (l % 2 == 0) ? s : ~s;
    endfunction

    // Product term t from the model map (R2, R3, R4)
    function automatic logic term_val(int t, logic [7:0] d, logic [7:0] f);
        for (int l = 0; l < 32; l++)
            if (mdl[t][l] && !line_val(l, d, f)) return 1'b0;
        return 1'b1;
    endfunction

    // Expected sum of group g (R5, R6)
    function automatic logic exp_sum(int g, logic [7:0] d, logic [7:0] f, logic [7:0] sel);
        logic r = 1'b0;
        for (int j = 0; j < 7; j++) r |= term_val(8*g+j, d, f);
        if (!sel[g]) r |= term_val(8*g+7, d, f);
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] w);
        @(negedge clk);
        map_we = 1'b1; map_addr = 6'(a); map_wdata = w;
        @(negedge clk);
        map_we = 1'b0;
        mdl[a] = w;
    endtask

    task automatic clear_all();
        @(negedge clk);
        map_clr = 1'b1;
        @(negedge clk);
        map_clr = 1'b0;
        for (int t = 0; t < 64; t++) mdl[t] = '0;
    endtask

    task automatic check_outputs(string req);
        logic [7:0] es, ex;
        #1;
        for (int g = 0; g < 8; g++) begin
            es[g] = exp_sum(g, ded_i, fb_i, xt_oe_sel);
            ex[g] = term_val(8*g+7, ded_i, fb_i);
        end
        check({req, " sum"}, 32'(sum_o), 32'(es));
        check("R7 xterm", 32'(xterm_o), 32'(ex));
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int t = 0; t < 64; t++) mdl[t] = '0;
        ded_i = 8'hA5; fb_i = 8'h3C;
        map_we = 1'b1; map_addr = 6'd9; map_wdata = '1;
        repeat (3) @(negedge clk);
        map_we = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R10 / R3: reset leaves the map empty and every term true
        for (int t = 0; t < 64; t++) begin
            map_addr = 6'(t); #1;
            check("R10 reset map", map_rdata, 32'h0);
        end
        check("R3 erased sums", 32'(sum_o), 32'hFF);
        check("R3 erased xterms", 32'(xterm_o), 32'hFF);

        // R8: random writes read back
        for (int t = 0; t < 64; t++)
            wr(t, $urandom() & $urandom() & $urandom() & $urandom());
        for (int t = 0; t < 64; t++) begin
            map_addr = 6'(t); #1;
            check("R8 readback", map_rdata, mdl[t]);
        end

        // R1/R2/R5/R6/R7: random vectors against sparse random maps
        for (int rnd = 0; rnd < 6; rnd++) begin
            for (int t = 0; t < 64; t++)
                wr(t, $urandom() & $urandom() & $urandom() & $urandom() & $urandom());
            for (int v = 0; v < 40; v++) begin
                @(negedge clk);
                ded_i = 8'($urandom()); fb_i = 8'($urandom()); xt_oe_sel = 8'($urandom());
                check_outputs("R2 R5 random");
            end
        end

        // R1: single-line connections select the matching signal and polarity
        clear_all();
        for (int l = 0; l < 32; l++) begin
            wr(7, 32'(1) << l);
            ded_i = 8'($urandom()); fb_i = 8'($urandom());
            #1;
            check("R1 line map", 32'(xterm_o[0]), 32'(line_val(l, ded_i, fb_i)));
        end

        // R4: contradictory terms in group 2 pull the sum to 0
        clear_all();
        for (int j = 0; j < 8; j++) wr(16+j, 32'h0000_0030);
        xt_oe_sel = 8'h00;
        for (int v = 0; v < 4; v++) begin
            ded_i = 8'($urandom()); fb_i = 8'($urandom()); #1;
            check("R4 contradiction sum", 32'(sum_o[2]), 32'h0);
            check("R4 contradiction xterm", 32'(xterm_o[2]), 32'h0);
        end

        // R6: group 1 with only the special term true
        clear_all();
        for (int j = 0; j < 7; j++) wr(8+j, 32'h0003_0000);
        xt_oe_sel = 8'h02; #1;
        check("R6 special excluded", 32'(sum_o[1]), 32'h0);
        check("R7 special visible", 32'(xterm_o[1]), 32'h1);
        xt_oe_sel = 8'h00; #1;
        check("R5 special included", 32'(sum_o[1]), 32'h1);

        // R11: input change with no clock edge reaches the outputs
        wr(15, 32'h0000_0001);
        @(posedge clk); #1;
        ded_i[0] = 1'b1; #1;
        check("R11 comb high", 32'(xterm_o[1]), 32'h1);
        ded_i[0] = 1'b0; #1;
        check("R11 comb low", 32'(xterm_o[1]), 32'h0);
        check("R11 comb sum", 32'(sum_o[1]), 32'h0);

        // R9: clear wins over a simultaneous write
        wr(20, 32'hDEAD_BEEF);
        @(negedge clk);
        map_clr = 1'b1; map_we = 1'b1; map_addr = 6'd20; map_wdata = 32'h1234_5678;
        @(negedge clk);
        map_clr = 1'b0; map_we = 1'b0;
        for (int t = 0; t < 64; t++) mdl[t] = '0;
        #1;
        check("R9 clear beats write", map_rdata, 32'h0);
        map_addr = 6'd15; #1;
        check("R9 clear other word", map_rdata, 32'h0);
        check("R9 erased outputs", 32'(xterm_o), 32'hFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule